// File: doc/BRIEF.md
# Pong Wall-Hit Score Keeper

This block keeps the two scores of a bat-and-ball video game. It samples the ball's horizontal coordinate each time the motion logic presents a new position through an update strobe. When the ball arrives at the left edge of the field, the player on the right earns a point. When it arrives at the right edge, the player on the left earns a point. Each arrival counts once, however many position updates the ball spends parked on that edge.

The scores are unsigned binary digits from 0 to 9, so a digit renderer can use them directly. When either player reaches the winning count, a game-over flag rises and both scores freeze until reset. Only the horizontal coordinate affects scoring, so the vertical coordinate is not an input. The field width (the right-edge coordinate) and the winning count are parameters.

Top module: `pong_score_keeper`

## Requirements
- R1: A synchronous active-high reset sets both scores to 0, drops `game_over` and forgets any earlier edge contact. A strobe at an edge right after reset therefore scores.
- R2: A strobe with `ball_x == 0` raises `score_right` by one at that clock edge, unless the previous strobe also had `ball_x == 0`.
- R3: A strobe with `ball_x == X_MAX` raises `score_left` by one at that clock edge, unless the previous strobe also had `ball_x == X_MAX`.
- R4: Further strobes at the same edge add nothing. A strobe anywhere off that edge re-arms it, and this includes a strobe at the opposite edge.
- R5: The scores change only on clock edges where `upd` is high. Changes of `ball_x` without a strobe are ignored and do not re-arm or disarm an edge.
- R6: `game_over` is high exactly while either score equals `WIN_PTS` (9 by default). While it is high, no strobe changes either score.
- R7: Each score is an unsigned binary value that never exceeds `WIN_PTS`.
- R8: When reset and a strobe at an edge fall in the same cycle, reset wins and both scores read 0 afterwards.
- R9: A strobe at any other coordinate, including values above `X_MAX`, changes no score.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| upd | input | 1 | Ball position update strobe |
| ball_x | input | XW | Ball horizontal coordinate |
| score_left | output | SW | Left player's score, 0..WIN_PTS |
| score_right | output | SW | Right player's score, 0..WIN_PTS |
| game_over | output | 1 | High while either score equals WIN_PTS |

## Verification
A point award can coincide with two other events, and both are checked.

The first is a reset. The bench asserts `rst` in the very cycle that a strobe delivers the ball to the left edge. It expects zero scores and a re-armed edge, which it confirms by scoring the very next strobe at that edge.

The second is the strobe that brings a score to nine. The bench plays one side up to the winning count and checks `game_over` after every award. It then sends hits at both edges and expects both scores to stay where they were.

// File: rtl/pong_score_pkg.sv
package pong_score_pkg;

  // Player index: the left player is credited for right-edge hits.
  typedef enum logic {
    PLAYER_LEFT  = 1'b0,
    PLAYER_RIGHT = 1'b1
  } player_e;

  // Edge index used by the contact detectors.
  localparam int unsigned EDGE_LEFT  = 0;
  localparam int unsigned EDGE_RIGHT = 1;
  localparam int unsigned NUM_EDGES  = 2;

endpackage

// File: rtl/pong_wall_sense.sv
module pong_wall_sense #(
  parameter int unsigned    XW   = 10,
  parameter logic [XW-1:0]  SPOT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic [XW-1:0] ball_x,
  output logic          entry
);

  logic on_spot;
  logic was_on_spot;

  assign on_spot = (ball_x == SPOT);

  // Pulse only for the first strobe that finds the ball on this edge.
  always_comb entry = upd && on_spot && !was_on_spot;

  always_ff @(posedge clk) begin
    if (rst) begin
      was_on_spot <= 1'b0;
    end else if (upd) begin
      was_on_spot <= on_spot;
    end
  end

endmodule

// File: rtl/pong_score_digit.sv
module pong_score_digit #(
  parameter int unsigned SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [SW-1:0] value
);

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else if (inc) begin
      value <= value + SW'(1);
    end
  end

endmodule

// File: rtl/pong_score_keeper.sv
module pong_score_keeper
  import pong_score_pkg::*;
#(
  parameter int unsigned XW      = 10,
  parameter int unsigned X_MAX   = 639,
  parameter int unsigned WIN_PTS = 9,
  localparam int unsigned SW     = $clog2(WIN_PTS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic [XW-1:0] ball_x,
  output logic [SW-1:0] score_left,
  output logic [SW-1:0] score_right,
  output logic          game_over
);

  localparam logic [XW-1:0] RIGHT_SPOT = XW'(X_MAX);
  localparam logic [SW-1:0] LAST_STEP  = SW'(WIN_PTS - 1);

  logic [NUM_EDGES-1:0] edge_entry;
  logic [1:0]           award;
  logic [SW-1:0]        score_q [2];

  // One contact detector per edge.
  for (genvar e = 0; e < NUM_EDGES; e++) begin : g_edge
    pong_wall_sense #(
      .XW   (XW),
      .SPOT ((e == EDGE_LEFT) ? {XW{1'b0}} : RIGHT_SPOT)
    ) sense_i (
      .clk    (clk),
      .rst    (rst),
      .upd    (upd),
      .ball_x (ball_x),
      .entry  (edge_entry[e])
    );
  end

  // Crosswise credit, blocked once the game is decided.
  always_comb begin
    award[PLAYER_LEFT]  = edge_entry[EDGE_RIGHT] && !game_over;
    award[PLAYER_RIGHT] = edge_entry[EDGE_LEFT]  && !game_over;
  end

  for (genvar p = 0; p < 2; p++) begin : g_player
    pong_score_digit #(
      .SW (SW)
    ) digit_i (
      .clk   (clk),
      .rst   (rst),
      .inc   (award[p]),
      .value (score_q[p])
    );
  end

  // Registered flag: set by the award that reaches the winning count.
  always_ff @(posedge clk) begin
    if (rst) begin
      game_over <= 1'b0;
    end else if ((award[PLAYER_LEFT]  && score_q[PLAYER_LEFT]  == LAST_STEP) ||
                 (award[PLAYER_RIGHT] && score_q[PLAYER_RIGHT] == LAST_STEP)) begin
      game_over <= 1'b1;
    end
  end

  assign score_left  = score_q[PLAYER_LEFT];
  assign score_right = score_q[PLAYER_RIGHT];

endmodule

// File: rtl/pong_score_keeper_chk.sv
module pong_score_keeper_chk #(
  parameter int unsigned XW      = 10,
  parameter int unsigned X_MAX   = 639,
  parameter int unsigned WIN_PTS = 9,
  parameter int unsigned SW      = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          upd,
  input logic [XW-1:0] ball_x,
  input logic [SW-1:0] score_left,
  input logic [SW-1:0] score_right,
  input logic          game_over
);

  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  p_clear_r1: assert property (@(posedge clk)
    rst |=> (score_left == '0 && score_right == '0 && !game_over));

  p_left_edge_r2: assert property (@(posedge clk) disable iff (rst || !armed)
    (score_right != $past(score_right)) |-> $past(upd && ball_x == '0));

  p_right_edge_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    (score_left != $past(score_left)) |-> $past(upd && ball_x == XW'(X_MAX)));

  p_no_strobe_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    !upd |=> ($stable(score_left) && $stable(score_right)));

  p_freeze_r6: assert property (@(posedge clk) disable iff (rst || !armed)
    game_over |=> ($stable(score_left) && $stable(score_right) && game_over));

  p_flag_match_r6: assert property (@(posedge clk) disable iff (rst || !armed)
    game_over == (score_left == SW'(WIN_PTS) || score_right == SW'(WIN_PTS)));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst || !armed)
    (score_left <= SW'(WIN_PTS)) && (score_right <= SW'(WIN_PTS)));

endmodule

bind pong_score_keeper pong_score_keeper_chk #(
  .XW      (XW),
  .X_MAX   (X_MAX),
  .WIN_PTS (WIN_PTS),
  .SW      (SW)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .upd         (upd),
  .ball_x      (ball_x),
  .score_left  (score_left),
  .score_right (score_right),
  .game_over   (game_over)
);

// File: tb/pong_score_keeper_tb_top.sv
`timescale 1ns/1ps
module pong_score_keeper_tb_top;

  localparam int unsigned XW      = 4;
  localparam int unsigned X_MAX   = 11;
  localparam int unsigned WIN_PTS = 9;
  localparam int unsigned SW      = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          upd = 1'b0;
  logic [XW-1:0] ball_x = '0;
  logic [SW-1:0] score_left;
  logic [SW-1:0] score_right;
  logic          game_over;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Reference state built from the requirements.
  int ml = 0;
  int mr = 0;
  bit on_l = 1'b0;
  bit on_r = 1'b0;

  always #2 clk = ~clk;

  pong_score_keeper #(
    .XW      (XW),
    .X_MAX   (X_MAX),
    .WIN_PTS (WIN_PTS)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .upd         (upd),
    .ball_x      (ball_x),
    .score_left  (score_left),
    .score_right (score_right),
    .game_over   (game_over)
  );

  task automatic check(input string tag);
    bit exp_over;
    exp_over = (ml == WIN_PTS) || (mr == WIN_PTS);
    checks++;
    if (int'(score_left) != ml || int'(score_right) != mr || game_over != exp_over) begin
      errors++;
      $display("FAIL %s: got L=%0d R=%0d over=%0b, expected L=%0d R=%0d over=%0b",
               tag, score_left, score_right, game_over, ml, mr, exp_over);
    end
  endtask

  task automatic model_clear();
    ml = 0; mr = 0; on_l = 1'b0; on_r = 1'b0;
  endtask

  task automatic strobe(input int x);
    bit hit_l, hit_r, over;
    @(negedge clk);
    upd = 1'b1;
    ball_x = XW'(x);
    hit_l = (x == 0) && !on_l;
    hit_r = (x == X_MAX) && !on_r;
    over  = (ml == WIN_PTS) || (mr == WIN_PTS);
    if (!over) begin
      if (hit_l) mr++;
      if (hit_r) ml++;
    end
    on_l = (x == 0);
    on_r = (x == X_MAX);
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 reset state");

    // Sweep every coordinate from an interior position (R2, R3, R9).
    for (int x = 0; x < (1 << XW); x++) begin
      strobe(5);
      strobe(x);
      if (x == 0)          check("R2 left edge credits right");
      else if (x == X_MAX) check("R3 right edge credits left");
      else                 check("R9 interior or beyond edge");
    end

    // Parked at an edge: a single point only (R4).
    strobe(5);
    for (int k = 0; k < 3; k++) begin
      strobe(0);
      check("R4 repeated left strobes");
    end
    strobe(X_MAX);
    check("R4 direct jump to right edge");
    strobe(X_MAX);
    check("R4 repeated right strobe");
    strobe(0);
    check("R4 jump back re-arms left");

    // Coordinate moves without a strobe are ignored (R5).
    strobe(6);
    @(negedge clk);
    ball_x = '0;
    repeat (3) @(negedge clk);
    check("R5 no strobe no change");
    strobe(0);
    check("R5 edge still armed after idle move");

    // Reset beats a same-cycle left-edge entry (R8).
    strobe(4);
    @(negedge clk);
    rst = 1'b1;
    upd = 1'b1;
    ball_x = '0;
    @(negedge clk);
    rst = 1'b0;
    upd = 1'b0;
    model_clear();
    check("R8 reset wins over hit");
    strobe(0);
    check("R1 reset forgets edge contact");

    // Play the right player up to the win (R6, R7).
    while (mr < WIN_PTS) begin
      strobe(3);
      strobe(0);
      check("R6 R7 climb to win");
    end
    strobe(X_MAX);
    check("R6 frozen after win right edge");
    strobe(2);
    strobe(0);
    check("R6 frozen after win left edge");
    checks++;
    if (score_right > SW'(WIN_PTS) || score_left > SW'(WIN_PTS)) begin
      errors++;
      $display("FAIL R7: got L=%0d R=%0d, expected at most %0d",
               score_left, score_right, WIN_PTS);
    end

    // Left player wins after a fresh reset (R3, R6).
    do_reset();
    check("R1 second reset");
    for (int k = 0; k < WIN_PTS + 2; k++) begin
      strobe(7);
      strobe(X_MAX);
      check("R3 R6 left player to win");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule